// File: doc/BRIEF.md
# Streaming Tournament-Tree Sorter with Run Colouring

The block sorts a stream of keys in ascending order. Each key carries a tag. A tournament tree with a fixed number of leaves holds the entries. The leaves keep the key, the tag and a colour. Every internal node keeps only a pointer to the leaf that lost the match played at that node. One magnitude comparator serves every match in the tree, at every level.

Operation moves through four phases:

- **Population.** The first batch of keys is written into the leaves one by one. Each sibling pair is decided when its second member arrives.
- **Level evaluation.** The upper levels are then settled with one match per cycle until a winner reaches the root.
- **Streaming.** Once the presented winner is taken, the next key goes into the freed leaf. It then replays only that leaf's path towards the root.
- **Flush.** A flush request fills freed leaves with dummy entries until every real key has left. The block then returns to population.

Every entry carries a 3-bit run colour. A key that is smaller than the key last emitted would break the ascending order, so it gets the next colour. A key that keeps the order stays in the current run. The tree orders entries by colour first and key second. A downstream stage can cut the output into runs wherever the colour changes. The all-ones colour is never given to a real key. When a key would need it, the block holds the key off, drains the tree and restarts colouring from zero.

Top module: `tourney_sorter`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. The block is in population and holds no keys.
- R2: After `N_LEAVES` keys have been accepted from empty, `out_valid` rises with the smallest of them, with colour 0, after no more than `N_LEAVES` further cycles.
- R3: Within one colour, emitted keys never decrease. A batch given to an empty block in any order comes out fully sorted with colour 0.
- R4: In streaming, a key is accepted only while no winner is presented, so `in_ready` and `out_valid` are never both 1. After an accept, `in_ready` and `out_valid` stay 0 through the next `log2(N_LEAVES)-1` cycles. The next winner is presented exactly `log2(N_LEAVES)` rising edges after the accepting edge.
- R5: A key accepted in streaming gets colour c+1 if it is smaller than the last emitted key, where c is the last emitted colour. Otherwise it gets colour c.
- R6: Emitted colours never decrease between restarts. The whole output sequence equals the replacement-selection order: the smallest (colour, key) held is emitted each time a slot is needed.
- R7: A one-cycle `flush` empties the block. Every held key is emitted in order and dummy entries (colour 7) are never emitted. The block then returns to population with `in_ready` at 1 and colour numbering back at 0. In the cycle `flush` is 1, `in_ready` is 0.
- R8: A flush during a partial population pads the missing leaves with dummies. The held keys are emitted sorted.
- R9: A key that would need colour 7 is not accepted (`in_ready` 0). The tree drains, and the same key then starts a new population with colour 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_key`, `out_tag` and `out_color` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input key offered |
| in_ready | output | 1 | Block accepts the offered key this cycle |
| in_key | input | KEY_W | Key to sort |
| in_tag | input | TAG_W | Tag travelling with the key |
| flush | input | 1 | One-cycle request to empty the block |
| out_valid | output | 1 | Sorted entry presented |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_key | output | KEY_W | Emitted key |
| out_tag | output | TAG_W | Emitted tag |
| out_color | output | COLOR_W | Run colour of the emitted entry |

## Verification
A flush request and a key offer can land in the same cycle, and the flush must win. The bench drives `flush` and `in_valid` together while the block would otherwise accept. It expects `in_ready` to be 0 in that cycle, every held key to drain, and the same key to be accepted afterwards as the first entry of a fresh colour-0 population. A separate directed test drives a long descending stream until colour 6 is exhausted. In that test, the block's own drain for colour wrap overlaps with the consumer taking winners. The complete output order is judged against a replacement-selection model kept in the bench.

// File: rtl/tsort_pkg.sv
package tsort_pkg;

    // Operating phase of the sorter
    typedef enum logic [1:0] {
        PH_POP    = 2'd0,   // serial leaf fill, first-level matches
        PH_LEVEL  = 2'd1,   // upper levels, one match per cycle
        PH_STREAM = 2'd2,   // winner presented / leaf slot free
        PH_WALK   = 2'd3    // replaying one leaf-to-root path
    } phase_e;

endpackage

// File: rtl/tsort_cmp.sv
// Shared comparator: decides whether entry B precedes entry A.
module tsort_cmp #(
    parameter int KEY_W   = 32,
    parameter int COLOR_W = 3
) (
    input  logic [COLOR_W-1:0] a_color,
    input  logic [KEY_W-1:0]   a_key,
    input  logic [COLOR_W-1:0] b_color,
    input  logic [KEY_W-1:0]   b_key,
    output logic               b_first
);
    always_comb begin
        b_first = {b_color, b_key} < {a_color, a_key};
    end
endmodule

// File: rtl/tsort_colorer.sv
// Assigns the run colour of an incoming key relative to the last emitted key.
module tsort_colorer #(
    parameter int KEY_W   = 32,
    parameter int COLOR_W = 3
) (
    input  logic               last_valid,
    input  logic [COLOR_W-1:0] last_color,
    input  logic [KEY_W-1:0]   last_key,
    input  logic [KEY_W-1:0]   key,
    output logic [COLOR_W-1:0] color,
    output logic               wrap
);
    localparam logic [COLOR_W-1:0] TOP_RUN = {{(COLOR_W-1){1'b1}}, 1'b0};

    logic breaks_order;

    always_comb begin
        breaks_order = last_valid && (key < last_key);
        if (!last_valid) begin
            color = '0;
        end else if (breaks_order) begin
            color = last_color + 1'b1;
        end else begin
            color = last_color;
        end
        wrap = breaks_order && (last_color == TOP_RUN);
    end
endmodule

// File: rtl/tourney_sorter.sv
module tourney_sorter
    import tsort_pkg::*;
#(
    parameter int N_LEAVES = 16,
    parameter int KEY_W    = 32,
    parameter int TAG_W    = 16,
    parameter int COLOR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [KEY_W-1:0]   in_key,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic               flush,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [KEY_W-1:0]   out_key,
    output logic [TAG_W-1:0]   out_tag,
    output logic [COLOR_W-1:0] out_color
);
    localparam int LVL  = $clog2(N_LEAVES);
    localparam int HALF = N_LEAVES / 2;
    localparam logic [COLOR_W-1:0] DUMMY = '1;

    typedef logic [LVL-1:0] ptr_t;

    typedef struct packed {
        logic [COLOR_W-1:0] color;
        logic [KEY_W-1:0]   key;
        logic [TAG_W-1:0]   tag;
    } entry_t;

    localparam entry_t DUMMY_E = {DUMMY, {KEY_W{1'b1}}, {TAG_W{1'b0}}};
    localparam ptr_t   ROOT    = ptr_t'(1);
    localparam ptr_t   P_HALF  = ptr_t'(HALF);
    localparam ptr_t   P_LAST  = ptr_t'(N_LEAVES - 1);

    typedef struct packed {
        phase_e             phase;
        ptr_t               fill;
        logic               pad;
        logic               drain;
        ptr_t               node;
        ptr_t               cur;
        ptr_t               win;
        logic               have_win;
        logic               last_valid;
        logic [KEY_W-1:0]   last_key;
        logic [COLOR_W-1:0] last_color;
    } state_t;

    state_t s_q, s_d;
    entry_t leaf_q  [N_LEAVES];
    entry_t leaf_d  [N_LEAVES];
    ptr_t   loser_q [N_LEAVES];
    ptr_t   loser_d [N_LEAVES];
    ptr_t   wtmp_q  [N_LEAVES];
    ptr_t   wtmp_d  [N_LEAVES];

    // Operand selection for the single shared comparator
    entry_t op_a, op_b, pop_e;
    ptr_t   kid_l, kid_r;
    logic   b_first;

    always_comb begin
        pop_e = s_q.pad ? DUMMY_E : {{COLOR_W{1'b0}}, in_key, in_tag};
        kid_l = {s_q.node[LVL-2:0], 1'b0};
        kid_r = {s_q.node[LVL-2:0], 1'b1};
        op_a  = leaf_q[0];
        op_b  = leaf_q[0];
        case (s_q.phase)
            PH_POP: begin
                op_a = leaf_q[{s_q.fill[LVL-1:1], 1'b0}];
                op_b = pop_e;
            end
            PH_LEVEL: begin
                op_a = leaf_q[wtmp_q[kid_l]];
                op_b = leaf_q[wtmp_q[kid_r]];
            end
            PH_WALK: begin
                op_a = leaf_q[s_q.cur];
                op_b = leaf_q[loser_q[s_q.node]];
            end
            default: begin
                op_a = leaf_q[0];
                op_b = leaf_q[0];
            end
        endcase
    end

    tsort_cmp #(.KEY_W(KEY_W), .COLOR_W(COLOR_W)) u_cmp (
        .a_color (op_a.color),
        .a_key   (op_a.key),
        .b_color (op_b.color),
        .b_key   (op_b.key),
        .b_first (b_first)
    );

    logic [COLOR_W-1:0] new_color;
    logic               new_wrap;

    tsort_colorer #(.KEY_W(KEY_W), .COLOR_W(COLOR_W)) u_color (
        .last_valid (s_q.last_valid),
        .last_color (s_q.last_color),
        .last_key   (s_q.last_key),
        .key        (in_key),
        .color      (new_color),
        .wrap       (new_wrap)
    );

    // Next-state logic
    entry_t win_e;
    ptr_t   fill_parent, win_parent, fill_mate, level_win, walk_win, node_ptr;

    always_comb begin
        s_d       = s_q;
        leaf_d    = leaf_q;
        loser_d   = loser_q;
        wtmp_d    = wtmp_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;

        win_e       = leaf_q[s_q.win];
        fill_parent = P_HALF + (s_q.fill >> 1);
        win_parent  = P_HALF + (s_q.win >> 1);
        fill_mate   = {s_q.fill[LVL-1:1], 1'b0};
        level_win   = b_first ? wtmp_q[kid_r] : wtmp_q[kid_l];
        node_ptr    = loser_q[s_q.node];
        walk_win    = b_first ? node_ptr : s_q.cur;

        case (s_q.phase)
            PH_POP: begin
                in_ready = !s_q.pad && !flush;
                if (!s_q.pad && flush && (s_q.fill != '0)) begin
                    s_d.pad   = 1'b1;
                    s_d.drain = 1'b1;
                end
                if (s_q.pad || (in_valid && in_ready)) begin
                    leaf_d[s_q.fill] = pop_e;
                    if (s_q.fill[0]) begin
                        loser_d[fill_parent] = b_first ? fill_mate : s_q.fill;
                        wtmp_d[fill_parent]  = b_first ? s_q.fill : fill_mate;
                    end
                    if (s_q.fill == P_LAST) begin
                        s_d.phase = PH_LEVEL;
                        s_d.node  = P_HALF - ROOT;
                        s_d.fill  = '0;
                    end else begin
                        s_d.fill = s_q.fill + ROOT;
                    end
                end
            end

            PH_LEVEL: begin
                if (flush) begin
                    s_d.drain = 1'b1;
                end
                loser_d[s_q.node] = b_first ? wtmp_q[kid_l] : wtmp_q[kid_r];
                wtmp_d[s_q.node]  = level_win;
                if (s_q.node == ROOT) begin
                    s_d.win      = level_win;
                    s_d.have_win = 1'b1;
                    s_d.pad      = 1'b0;
                    s_d.phase    = PH_STREAM;
                end else begin
                    s_d.node = s_q.node - ROOT;
                end
            end

            PH_STREAM: begin
                if (flush) begin
                    s_d.drain = 1'b1;
                end
                if (s_q.have_win) begin
                    if (win_e.color == DUMMY) begin
                        // only dummies remain: start a fresh population
                        s_d.phase      = PH_POP;
                        s_d.fill       = '0;
                        s_d.pad        = 1'b0;
                        s_d.drain      = 1'b0;
                        s_d.have_win   = 1'b0;
                        s_d.last_valid = 1'b0;
                        s_d.last_color = '0;
                    end else begin
                        out_valid = 1'b1;
                        if (out_ready) begin
                            s_d.have_win   = 1'b0;
                            s_d.last_valid = 1'b1;
                            s_d.last_key   = win_e.key;
                            s_d.last_color = win_e.color;
                        end
                    end
                end else if (s_q.drain) begin
                    leaf_d[s_q.win] = DUMMY_E;
                    s_d.phase = PH_WALK;
                    s_d.cur   = s_q.win;
                    s_d.node  = win_parent;
                end else begin
                    in_ready = !flush && !(in_valid && new_wrap);
                    if (in_valid && new_wrap && !flush) begin
                        s_d.drain = 1'b1;
                    end
                    if (in_valid && in_ready) begin
                        leaf_d[s_q.win] = {new_color, in_key, in_tag};
                        s_d.phase = PH_WALK;
                        s_d.cur   = s_q.win;
                        s_d.node  = win_parent;
                    end
                end
            end

            PH_WALK: begin
                if (flush) begin
                    s_d.drain = 1'b1;
                end
                if (b_first) begin
                    loser_d[s_q.node] = s_q.cur;
                end
                if (s_q.node == ROOT) begin
                    s_d.win      = walk_win;
                    s_d.have_win = 1'b1;
                    s_d.phase    = PH_STREAM;
                end else begin
                    s_d.cur  = walk_win;
                    s_d.node = s_q.node >> 1;
                end
            end

            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < N_LEAVES; i++) begin
                leaf_q[i]  <= '0;
                loser_q[i] <= '0;
                wtmp_q[i]  <= '0;
            end
        end else begin
            s_q     <= s_d;
            leaf_q  <= leaf_d;
            loser_q <= loser_d;
            wtmp_q  <= wtmp_d;
        end
    end

    assign out_key   = win_e.key;
    assign out_tag   = win_e.tag;
    assign out_color = win_e.color;

    // Emitted keys within one run never decrease
    p_run_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && s_q.last_valid && out_color == s_q.last_color)
            |-> (out_key >= s_q.last_key));

    // Run colours only move forward between restarts
    p_color_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && s_q.last_valid) |-> (out_color >= s_q.last_color));

    // Dummy entries never leave the block
    p_no_dummy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_color != DUMMY));

    // Presented entry holds under backpressure
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key)
                                        && $stable(out_tag) && $stable(out_color)));

    // An accepted streaming key locks both handshakes while its path replays
    p_walk_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && s_q.phase == PH_STREAM) |=> (!out_valid && !in_ready));

    // Input and output handshakes are never open together
    p_ready_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && in_ready));

    // Flush request always closes the input for that cycle
    p_flush_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

endmodule

// File: tb/tb_tourney_sorter.sv
`timescale 1ns/1ps
module tb_tourney_sorter;
    localparam int N     = 16;
    localparam int LOG_N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_key = '0;
    logic [15:0] in_tag = '0;
    logic        flush = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_key;
    logic [15:0] out_tag;
    logic [2:0]  out_color;

    always #2.5 clk = ~clk;

    tourney_sorter dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_tag(in_tag),
        .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_key(out_key), .out_tag(out_tag), .out_color(out_color)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference model of replacement selection
    longint pool_k[$];
    int     pool_t[$];
    int     pool_c[$];
    longint exp_k[$];
    int     exp_t[$];
    int     exp_c[$];
    longint got_k[$];
    int     got_t[$];
    int     got_c[$];
    bit     m_stream = 0;
    bit     m_lv     = 0;
    longint m_lk     = 0;
    int     m_lc     = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic void m_pop_min();
        int best = 0;
        for (int i = 1; i < pool_k.size(); i++) begin
            if ((longint'(pool_c[i]) << 33) + pool_k[i] <
                (longint'(pool_c[best]) << 33) + pool_k[best]) best = i;
        end
        exp_k.push_back(pool_k[best]);
        exp_t.push_back(pool_t[best]);
        exp_c.push_back(pool_c[best]);
        m_lv = 1; m_lk = pool_k[best]; m_lc = pool_c[best];
        pool_k.delete(best); pool_t.delete(best); pool_c.delete(best);
    endfunction

    function automatic void m_reset();
        m_lv = 0; m_lc = 0; m_stream = 0;
    endfunction

    function automatic void m_fill(input longint k, input int t);
        pool_k.push_back(k); pool_t.push_back(t); pool_c.push_back(0);
        if (pool_k.size() == N) m_stream = 1;
    endfunction

    function automatic void m_flush();
        while (pool_k.size() > 0) m_pop_min();
        m_reset();
    endfunction

    function automatic void m_push(input longint k, input int t);
        int c;
        if (!m_stream) begin
            m_fill(k, t);
        end else begin
            m_pop_min();
            c = (k < m_lk) ? m_lc + 1 : m_lc;
            if (c == 7) begin
                m_flush();
                m_fill(k, t);
            end else begin
                pool_k.push_back(k); pool_t.push_back(t); pool_c.push_back(c);
            end
        end
    endfunction

    // output monitor
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            got_k.push_back(out_key);
            got_t.push_back(out_tag);
            got_c.push_back(out_color);
        end
    end

    task automatic push(input longint k, input int t);
        in_key = k[31:0]; in_tag = t[15:0]; in_valid = 1'b1; #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        m_push(k, t);
    endtask

    task automatic settle();
        int quiet = 0;
        for (int i = 0; i < 3000 && quiet < 4; i++) begin
            @(negedge clk); #1;
            if (in_ready && !out_valid) quiet++; else quiet = 0;
        end
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        m_flush();
        settle();
    endtask

    task automatic compare_out(input string req);
        chk(got_k.size() == exp_k.size(), req, "output count", got_k.size(), exp_k.size());
        for (int i = 0; i < exp_k.size() && i < got_k.size(); i++) begin
            chk(got_k[i] == exp_k[i], req, $sformatf("key #%0d", i), got_k[i], exp_k[i]);
            chk(got_c[i] == exp_c[i], req, $sformatf("color #%0d", i), got_c[i], exp_c[i]);
            chk(got_t[i] == exp_t[i], req, $sformatf("tag #%0d", i), got_t[i], exp_t[i]);
        end
        got_k.delete(); got_t.delete(); got_c.delete();
        exp_k.delete(); exp_t.delete(); exp_c.delete();
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_batch();
        longint mn = 1 << 40;
        bit seen = 0;
        out_ready = 1'b0;
        for (int i = 0; i < N; i++) begin
            longint k = ((i * 37) % 101) + 200;
            if (k < mn) mn = k;
            push(k, 100 + i);
        end
        for (int i = 0; i < N + 2 && !seen; i++) begin
            @(negedge clk); #1;
            if (out_valid) seen = 1;
        end
        chk(seen, "R2", "first winner presented", seen, 1);
        chk(out_key == mn[31:0], "R2", "first winner key", out_key, mn);
        chk(out_color == 3'd0, "R2", "first winner color", out_color, 0);
        out_ready = 1'b1;
        do_flush();
        compare_out("R3");
        chk(in_ready == 1'b1, "R7", "ready after flush", in_ready, 1);
    endtask

    task automatic t_timing_hold();
        longint held;
        for (int i = 0; i < N; i++) push(1000 + i * 3, i);
        push(1001, 77);
        // now one sample after the accepting edge
        chk(!in_ready && !out_valid, "R4", "locked after accept, edge 0", {in_ready, out_valid}, 0);
        for (int e = 1; e < LOG_N; e++) begin
            @(negedge clk);
            if (e == LOG_N - 1) out_ready = 1'b0;
            #1;
            chk(!in_ready && !out_valid, "R4", $sformatf("locked edge %0d", e),
                {in_ready, out_valid}, 0);
        end
        @(negedge clk); #1;
        chk(out_valid == 1'b1, "R4", "winner after log2 edges", out_valid, 1);
        chk(in_ready == 1'b0, "R4", "ready low while presenting", in_ready, 0);
        held = out_key;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(out_valid && out_key == held[31:0], "R10", "held under backpressure", out_key, held);
        end
        out_ready = 1'b1;
        do_flush();
        compare_out("R4");
    endtask

    task automatic t_colors();
        for (int i = 0; i < 40; i++) push(((i * 37) % 101) + 10, 300 + i);
        do_flush();
        compare_out("R5");
    endtask

    task automatic t_partial();
        push(50, 1); push(20, 2); push(90, 3); push(10, 4); push(70, 5);
        do_flush();
        compare_out("R8");
        chk(in_ready == 1'b1, "R8", "ready after padded flush", in_ready, 1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < N; i++) push(6000 + i, i);
        for (int i = 0; i < 120; i++) push(5000 - i, 500 + i);
        do_flush();
        compare_out("R9");
    endtask

    task automatic t_collide();
        for (int i = 0; i < N + 3; i++) push(((i * 13) % 41) + 400, 900 + i);
        // wait for a cycle where a key could be taken
        for (int i = 0; i < 50 && !in_ready; i++) begin @(negedge clk); #1; end
        in_key = 32'd5; in_tag = 16'd999; in_valid = 1'b1; flush = 1'b1; #1;
        chk(in_ready == 1'b0, "R7", "ready with flush and offer together", in_ready, 0);
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        m_flush();
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        m_push(5, 999);
        do_flush();
        compare_out("R6");
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_batch();
        t_timing_hold();
        t_colors();
        t_partial();
        t_wrap();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule